// File: doc/BRIEF.md
# Palettized Pixel Unpacker

This block sits between a display-data buffer and the pixel pipeline of a display controller. It takes 64-bit words of packed frame data through a ready/valid handshake. It cuts each word into pixels of the selected depth and sends one pixel per cycle down a valid/ready output stream. In the indexed depths (1, 2, 4 and 8 bits), each extracted field addresses a 256-entry, 16-bit colour lookup table. In the direct depths (16 and 24 bits), the field itself becomes the colour.

The lookup table is written through a 32-bit port, and each word written carries a pair of entries. The order in which pixels are taken from a word is selectable. Pixels can be taken from the least significant end, from the most significant end, or in a mixed order where bytes are walked from the low end but pixels inside each byte start at the high end. Depth, order and the panel-type flag are captured together with each input word, so the configuration may change while earlier words are still being emitted.

Top module: `pixu_unpack`

## Requirements
- R1: After reset, `pix_valid` is 0 and `in_ready` is 1.
- R2: Depth codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel, indexed. One word yields 64/bpp pixels, and each pixel is `{8'h00, entry}` for the table entry addressed by its field.
- R3: Table entry i is held in table word i>>1: bits 15:0 hold the even entry and bits 31:16 hold the odd entry. A write (`pal_we`, 7-bit `pal_addr`, 32-bit `pal_wdata`) replaces both entries of that word.
- R4: When a table lookup and a write to the same table word happen in the same cycle, the lookup returns the value held before the write.
- R5: Depth code 4 selects 16 bpp direct colour. Four pixels are produced per word, each `{8'h00, field}`, and the table is not used.
- R6: Depth code 5 with `cfg_tft`=1 selects 24 bpp direct colour. It produces two pixels per word from bits 23:0 and 47:24 (in big-endian order the pixel from bits 47:24 comes first), and bits 63:48 are ignored. With `cfg_tft`=0, depth code 5 is handled as 16 bpp direct.
- R7: Order code 0 (little-endian): pixel k is taken from bits [k*bpp +: bpp].
- R8: Order code 1 (big-endian): pixel k is taken from bits [64-(k+1)*bpp +: bpp].
- R9: Order code 2 (mixed): below 8 bpp, pixel k is taken from byte k/(8/bpp), counting from the byte's most significant bit. At 8 bpp and above this order equals order 0.
- R10: `in_ready` rises only while the word register is empty or its last pixel is moving onward. While `pix_valid` is high and `pix_ready` is low, `pix_color` and `pix_valid` hold.
- R11: Depth codes 6 and 7 are handled as 16 bpp direct, and order code 3 as order 0.
- R12: Depth, order and panel flag are captured when a word is accepted. Changing them afterwards does not alter that word's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 64 | Packed display word |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle when high with `in_valid` |
| cfg_bpp | input | 3 | Pixel depth code |
| cfg_order | input | 2 | Pixel extraction order code |
| cfg_tft | input | 1 | Panel-type flag, enables 24 bpp |
| pal_we | input | 1 | Table write strobe |
| pal_addr | input | 7 | Table word address |
| pal_wdata | input | 32 | Two table entries, odd entry in the upper half |
| pix_color | output | 24 | Pixel colour |
| pix_valid | output | 1 | Pixel present |
| pix_ready | input | 1 | Downstream takes the pixel |

## Verification
Each depth is driven with asymmetric words whose fields all differ, so a swapped, shifted or wrongly masked field yields a different colour. The same word is replayed under all three orders, which separates little-endian, big-endian and mixed ordering and shows that mixed order collapses to little-endian at 8 bpp. Reserved codes and 24 bpp on a non-TFT panel are compared against the 16 bpp result. A table write timed onto the first lookup shows the old-data return, and a stalled, then irregular `pix_ready` with a second word waiting tests the hold behaviour and the word-to-word pixel order.

// File: rtl/pixu_pkg.sv
package pixu_pkg;

   typedef enum logic [2:0] {
      BPP1  = 3'd0,
      BPP2  = 3'd1,
      BPP4  = 3'd2,
      BPP8  = 3'd3,
      BPP16 = 3'd4,
      BPP24 = 3'd5
   } bpp_e;

   typedef enum logic [1:0] {
      ORD_LE  = 2'd0,
      ORD_BE  = 2'd1,
      ORD_MIX = 2'd2,
      ORD_RSV = 2'd3
   } ord_e;

   // log2 of pixel width for the power-of-two depths (24 bpp handled apart)
   function automatic int unsigned bpp_log2(bpp_e b);
      case (b)
         BPP1:    return 0;
         BPP2:    return 1;
         BPP4:    return 2;
         BPP8:    return 3;
         default: return 4;
      endcase
   endfunction

   function automatic logic bpp_is_indexed(bpp_e b);
      return (b == BPP1) || (b == BPP2) || (b == BPP4) || (b == BPP8);
   endfunction

endpackage

// File: rtl/pixu_cfg_decode.sv
module pixu_cfg_decode
   import pixu_pkg::*;
(
   input  logic [2:0] raw_bpp,
   input  logic [1:0] raw_order,
   input  logic       raw_tft,
   output bpp_e       eff_bpp,
   output ord_e       eff_order
);

   // Reserved depth codes and 24 bpp on a non-TFT panel fall back to 16 bpp
   always_comb begin
      if (raw_bpp <= 3'd4)
         eff_bpp = bpp_e'(raw_bpp);
      else if (raw_bpp == 3'd5 && raw_tft)
         eff_bpp = BPP24;
      else
         eff_bpp = BPP16;
   end

   assign eff_order = (raw_order == 2'd3) ? ORD_LE : ord_e'(raw_order);

endmodule

// File: rtl/pixu_slicer.sv
module pixu_slicer
   import pixu_pkg::*;
#(
   parameter int unsigned WORD_W  = 64,
   parameter int unsigned FIELD_W = 24,
   parameter bit          MIX_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WORD_W-1:0]  in_data,
   input  logic               in_valid,
   output logic               in_ready,
   input  bpp_e               cfg_bpp,
   input  ord_e               cfg_ord,
   input  logic               out_free,
   output logic               take,
   output logic [FIELD_W-1:0] field,
   output logic               indexed
);

   localparam int unsigned CNT_W  = $clog2(WORD_W);
   localparam int unsigned NPIX24 = WORD_W / 24;

   function automatic int unsigned npix_m1(bpp_e b);
      if (b == BPP24) return NPIX24 - 1;
      return (WORD_W >> bpp_log2(b)) - 1;
   endfunction

   logic [WORD_W-1:0]  word_q;
   logic               have_q;
   logic [CNT_W-1:0]   cnt_q;
   bpp_e               bpp_q;
   ord_e               ord_q;
   ord_e               ord_used;
   logic [CNT_W-1:0]   last_idx;
   logic               last;
   logic               load;

   int unsigned        k, lg, bw, ppb, pos;
   logic [WORD_W-1:0]  shifted;
   logic [FIELD_W-1:0] fmask;

   generate
      if (MIX_EN) begin : g_mix
         assign ord_used = ord_q;
      end else begin : g_nomix
         assign ord_used = (ord_q == ORD_MIX) ? ORD_LE : ord_q;
      end
   endgenerate

   assign last_idx = CNT_W'(npix_m1(bpp_q));
   assign last     = (cnt_q == last_idx);
   assign take     = have_q && out_free;
   assign in_ready = !have_q || (take && last);
   assign load     = in_valid && in_ready;
   assign indexed  = bpp_is_indexed(bpp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         have_q <= 1'b0;
         cnt_q  <= '0;
         bpp_q  <= BPP1;
         ord_q  <= ORD_LE;
      end else if (load) begin
         word_q <= in_data;
         bpp_q  <= cfg_bpp;
         ord_q  <= cfg_ord;
         cnt_q  <= '0;
         have_q <= 1'b1;
      end else if (take) begin
         if (last) begin
            have_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // Bit offset of the current pixel inside the held word
   always_comb begin
      k   = 32'(cnt_q);
      lg  = bpp_log2(bpp_q);
      bw  = 32'd1 << lg;
      ppb = 32'd8 >> lg;
      pos = k << lg;
      if (bpp_q == BPP24) begin
         bw  = 24;
         pos = (ord_used == ORD_BE) ? (NPIX24 - 1 - k) * 24 : k * 24;
      end else if (ord_used == ORD_BE) begin
         pos = WORD_W - ((k + 1) << lg);
      end else if (ord_used == ORD_MIX && lg < 3) begin
         pos = ((k >> (3 - lg)) << 3) + 8 - (((k & (ppb - 1)) + 1) << lg);
      end
   end

   assign shifted = word_q >> pos;
   assign fmask   = (bw >= FIELD_W) ? '1 : FIELD_W'((32'd1 << bw) - 1);
   assign field   = shifted[FIELD_W-1:0] & fmask;

   assert_accept_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> have_q);

   assert_count_in_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      have_q |-> (cnt_q <= last_idx));

endmodule

// File: rtl/pixu_pal_ram.sv
module pixu_pal_ram #(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned DW    = 32,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic          re,
   input  logic [AW-1:0] ra,
   output logic [DW-1:0] rd
);

   logic [DW-1:0] mem [DEPTH];

   // Write and registered read in one process: a colliding read sees old data
   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
      if (re) rd <= mem[ra];
   end

   assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rd));

endmodule

// File: rtl/pixu_out_stage.sv
module pixu_out_stage #(
   parameter int unsigned FIELD_W = 24,
   parameter int unsigned ENTRY_W = 16,
   parameter int unsigned IDX_W   = 8,
   localparam int unsigned PW_W   = 2 * ENTRY_W,
   localparam int unsigned RA_W   = IDX_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic [FIELD_W-1:0] field,
   input  logic               indexed,
   output logic               out_free,
   output logic               ram_re,
   output logic [RA_W-1:0]    ram_ra,
   input  logic [PW_W-1:0]    ram_rd,
   output logic [FIELD_W-1:0] pix_color,
   output logic               pix_valid,
   input  logic               pix_ready
);

   logic               valid_q;
   logic               half_q;
   logic               indexed_q;
   logic [FIELD_W-1:0] direct_q;
   logic [ENTRY_W-1:0] entry;

   assign out_free = !valid_q || pix_ready;
   assign ram_re   = take;
   assign ram_ra   = field[IDX_W-1:1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         half_q    <= 1'b0;
         indexed_q <= 1'b0;
         direct_q  <= '0;
      end else if (take) begin
         valid_q   <= 1'b1;
         half_q    <= field[0];
         indexed_q <= indexed;
         direct_q  <= field;
      end else if (pix_ready) begin
         valid_q <= 1'b0;
      end
   end

   assign entry     = half_q ? ram_rd[PW_W-1:ENTRY_W] : ram_rd[ENTRY_W-1:0];
   assign pix_color = indexed_q ? FIELD_W'(entry) : direct_q;
   assign pix_valid = valid_q;

   assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_color)));

   assert_take_emits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> pix_valid);

endmodule

// File: rtl/pixu_unpack.sv
module pixu_unpack
   import pixu_pkg::*;
#(
   parameter int unsigned WORD_W      = 64,
   parameter int unsigned PIX_W       = 24,
   parameter int unsigned ENTRY_W     = 16,
   parameter int unsigned PAL_ENTRIES = 256,
   parameter bit          MIX_EN      = 1'b1,
   localparam int unsigned PAL_DEPTH  = PAL_ENTRIES / 2,
   localparam int unsigned PAL_AW     = $clog2(PAL_DEPTH),
   localparam int unsigned IDX_W      = $clog2(PAL_ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [WORD_W-1:0]    in_data,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [2:0]           cfg_bpp,
   input  logic [1:0]           cfg_order,
   input  logic                 cfg_tft,
   input  logic                 pal_we,
   input  logic [PAL_AW-1:0]    pal_addr,
   input  logic [2*ENTRY_W-1:0] pal_wdata,
   output logic [PIX_W-1:0]     pix_color,
   output logic                 pix_valid,
   input  logic                 pix_ready
);

   initial begin
      assert (WORD_W % 64 == 0) else $error("WORD_W must be a multiple of 64");
      assert (PIX_W == 24) else $error("PIX_W must be 24");
      assert (ENTRY_W <= PIX_W) else $error("ENTRY_W exceeds PIX_W");
      assert (PAL_ENTRIES >= 256 && (PAL_ENTRIES & (PAL_ENTRIES - 1)) == 0)
         else $error("PAL_ENTRIES must be a power of two of at least 256");
   end

   bpp_e               eff_bpp;
   ord_e               eff_ord;
   logic               out_free;
   logic               take;
   logic [PIX_W-1:0]   field;
   logic               indexed;
   logic               ram_re;
   logic [PAL_AW-1:0]  ram_ra;
   logic [2*ENTRY_W-1:0] ram_rd;

   pixu_cfg_decode u_dec (
      .raw_bpp   (cfg_bpp),
      .raw_order (cfg_order),
      .raw_tft   (cfg_tft),
      .eff_bpp   (eff_bpp),
      .eff_order (eff_ord)
   );

   pixu_slicer #(.WORD_W(WORD_W), .FIELD_W(PIX_W), .MIX_EN(MIX_EN)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (in_data),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .cfg_bpp  (eff_bpp),
      .cfg_ord  (eff_ord),
      .out_free (out_free),
      .take     (take),
      .field    (field),
      .indexed  (indexed)
   );

   pixu_pal_ram #(.DEPTH(PAL_DEPTH), .DW(2*ENTRY_W)) u_pal (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (pal_we),
      .wa    (pal_addr),
      .wd    (pal_wdata),
      .re    (ram_re),
      .ra    (ram_ra),
      .rd    (ram_rd)
   );

   pixu_out_stage #(.FIELD_W(PIX_W), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .field     (field),
      .indexed   (indexed),
      .out_free  (out_free),
      .ram_re    (ram_re),
      .ram_ra    (ram_ra),
      .ram_rd    (ram_rd),
      .pix_color (pix_color),
      .pix_valid (pix_valid),
      .pix_ready (pix_ready)
   );

   assert_no_accept_while_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready && $past(pix_valid && !pix_ready)) |-> !(in_ready && $past(in_ready) == 1'b0 && take));

endmodule

// File: tb/sim_pixu_unpack.sv
module sim_pixu_unpack;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [2:0]  cfg_bpp = 3'd0;
   logic [1:0]  cfg_order = 2'd0;
   logic        cfg_tft = 1'b0;
   logic        pal_we = 1'b0;
   logic [6:0]  pal_addr = '0;
   logic [31:0] pal_wdata = '0;
   logic [23:0] pix_color;
   logic        pix_valid;
   logic        pix_ready = 1'b1;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;
   logic [15:0] pal_model [256];

   always #5 clk = ~clk;

   pixu_unpack u0 (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .cfg_bpp(cfg_bpp), .cfg_order(cfg_order),
      .cfg_tft(cfg_tft), .pal_we(pal_we), .pal_addr(pal_addr),
      .pal_wdata(pal_wdata), .pix_color(pix_color), .pix_valid(pix_valid),
      .pix_ready(pix_ready)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         $display("FAIL watchdog: got hang expected completion");
         miscompares = miscompares + 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic check(input logic [23:0] act, input logic [23:0] exp, input string tag);
      vectors = vectors + 1;
      if (act !== exp) begin
         miscompares = miscompares + 1;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int eff_depth(input int code, input bit tft);
      if (code > 5) return 4;
      if (code == 5 && !tft) return 4;
      return code;
   endfunction

   function automatic int npix_of(input int d);
      case (d)
         0: return 64;
         1: return 32;
         2: return 16;
         3: return 8;
         4: return 4;
         default: return 2;
      endcase
   endfunction

   function automatic logic [23:0] ref_pix(input logic [63:0] w, input int d, input int ord, input int k);
      int b, pos, per, o;
      logic [63:0] v;
      o = (ord == 3) ? 0 : ord;
      if (d == 5) begin
         pos = (o == 1) ? ((k == 0) ? 24 : 0) : k * 24;
         v = w >> pos;
         return v[23:0];
      end
      b = 1 << d;
      if (o == 1) pos = 64 - (k + 1) * b;
      else if (o == 2 && b < 8) begin
         per = 8 / b;
         pos = (k / per) * 8 + 8 - ((k % per) + 1) * b;
      end else pos = k * b;
      v = (w >> pos) & ((64'd1 << b) - 1);
      if (d <= 3) return {8'h00, pal_model[v[7:0]]};
      return v[23:0];
   endfunction

   task automatic pal_write(input logic [6:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      pal_we = 1'b1; pal_addr = a; pal_wdata = d;
      @(posedge clk); #2;
      pal_we = 1'b0;
      pal_model[{a, 1'b0}] = d[15:0];
      pal_model[{a, 1'b1}] = d[31:16];
   endtask

   // Send one word, scramble config after acceptance (R12), collect all pixels
   task automatic run_word(input logic [63:0] w, input int code, input int ord, input bit tft, input string tag);
      int d, n, got;
      d = eff_depth(code, tft);
      n = npix_of(d);
      @(posedge clk); #2;
      cfg_bpp = 3'(code); cfg_order = 2'(ord); cfg_tft = tft;
      in_data = w; in_valid = 1'b1;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #2;
      in_valid = 1'b0;
      cfg_bpp = 3'd1; cfg_order = 2'd1; cfg_tft = 1'b0; in_data = ~w;
      got = 0;
      while (got < n) begin
         @(negedge clk);
         if (pix_valid) begin
            check(pix_color, ref_pix(w, d, ord, got), $sformatf("%s R12 pixel %0d", tag, got));
            got++;
         end
      end
   endtask

   task automatic test_reset;
      @(negedge clk);
      check({23'd0, pix_valid}, 24'd0, "R1 pix_valid after reset");
      check({23'd0, in_ready}, 24'd1, "R1 in_ready after reset");
   endtask

   task automatic test_palette_fill;
      for (int i = 0; i < 128; i++)
         pal_write(7'(i), {16'((2*i+1) * 40503) ^ 16'h3C5A, 16'((2*i) * 40503) ^ 16'h1234});
   endtask

   task automatic test_indexed;
      run_word(64'hA5C3_0F96_1E87_D24B, 0, 0, 1'b0, "R2 R7 1bpp le");
      run_word(64'h1B2D_3C4E_5F60_7182, 1, 0, 1'b0, "R2 R7 2bpp le");
      run_word(64'h0123_4567_89AB_CDEF, 2, 0, 1'b0, "R2 R3 4bpp le");
      run_word(64'hF1E2_D3C4_B5A6_9788, 3, 0, 1'b0, "R2 R3 8bpp le");
   endtask

   task automatic test_orders;
      run_word(64'hA5C3_0F96_1E87_D24B, 0, 1, 1'b0, "R8 1bpp be");
      run_word(64'h0123_4567_89AB_CDEF, 2, 1, 1'b0, "R8 4bpp be");
      run_word(64'hF1E2_D3C4_B5A6_9788, 3, 1, 1'b0, "R8 8bpp be");
      run_word(64'hA5C3_0F96_1E87_D24B, 0, 2, 1'b0, "R9 1bpp mixed");
      run_word(64'h1B2D_3C4E_5F60_7182, 1, 2, 1'b0, "R9 2bpp mixed");
      run_word(64'h0123_4567_89AB_CDEF, 2, 2, 1'b0, "R9 4bpp mixed");
      run_word(64'hF1E2_D3C4_B5A6_9788, 3, 2, 1'b0, "R9 8bpp mixed as le");
   endtask

   task automatic test_direct;
      run_word(64'h1234_5678_9ABC_DEF0, 4, 0, 1'b0, "R5 16bpp le");
      run_word(64'h1234_5678_9ABC_DEF0, 4, 1, 1'b0, "R5 R8 16bpp be");
      run_word(64'hFFFF_A1B2_C3D4_E5F6, 5, 0, 1'b1, "R6 24bpp le");
      run_word(64'hFFFF_A1B2_C3D4_E5F6, 5, 1, 1'b1, "R6 24bpp be");
      run_word(64'hFFFF_A1B2_C3D4_E5F6, 5, 0, 1'b0, "R6 24bpp non-tft as 16");
      run_word(64'h0F1E_2D3C_4B5A_6978, 6, 0, 1'b1, "R11 code6 as 16");
      run_word(64'h0F1E_2D3C_4B5A_6978, 7, 1, 1'b1, "R11 code7 as 16");
      run_word(64'h0123_4567_89AB_CDEF, 2, 3, 1'b0, "R11 order3 as le");
   endtask

   // Lookup and write to word 0 in the same cycle: first pixel sees old entry
   task automatic test_collision;
      logic [15:0] old0;
      int got;
      old0 = pal_model[0];
      @(posedge clk); #2;
      cfg_bpp = 3'd3; cfg_order = 2'd0; in_data = 64'd0; in_valid = 1'b1;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #2;
      in_valid = 1'b0;
      pal_we = 1'b1; pal_addr = 7'd0; pal_wdata = 32'hBEEF_CAFE;
      @(posedge clk); #2;
      pal_we = 1'b0;
      pal_model[0] = 16'hCAFE; pal_model[1] = 16'hBEEF;
      got = 0;
      while (got < 8) begin
         @(negedge clk);
         if (pix_valid) begin
            check(pix_color, {8'h00, (got == 0) ? old0 : 16'hCAFE},
                  $sformatf("R4 R3 collision pixel %0d", got));
            got++;
         end
      end
   endtask

   task automatic test_backpressure;
      logic [63:0] wa, wb;
      int got, it;
      bit acc_b;
      wa = 64'h8877_6655_4433_2211;
      wb = 64'h0102_0408_1020_4080;
      @(posedge clk); #2;
      pix_ready = 1'b0;
      cfg_bpp = 3'd3; cfg_order = 2'd0; in_data = wa; in_valid = 1'b1;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #2;
      in_data = wb;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (i > 0) begin
            check({23'd0, pix_valid}, 24'd1, "R10 valid held in stall");
            check({23'd0, in_ready}, 24'd0, "R10 no accept in stall");
            check(pix_color, ref_pix(wa, 3, 0, 0), "R10 colour held in stall");
         end
      end
      got = 0; it = 0; acc_b = 1'b0;
      while (got < 16 && it < 200) begin
         @(posedge clk); #2;
         if (acc_b) in_valid = 1'b0;
         pix_ready = (it % 3 != 2);
         @(negedge clk);
         if (in_valid && in_ready) acc_b = 1'b1;
         if (pix_valid && pix_ready) begin
            check(pix_color, (got < 8) ? ref_pix(wa, 3, 0, got) : ref_pix(wb, 3, 0, got - 8),
                  $sformatf("R10 drain pixel %0d", got));
            got++;
         end
         it++;
      end
      check(24'(got), 24'd16, "R10 pixel count after drain");
      @(posedge clk); #2;
      in_valid = 1'b0; pix_ready = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      test_reset();
      test_palette_fill();
      test_indexed();
      test_orders();
      test_direct();
      test_collision();
      test_backpressure();
      run_word(64'h0123_4567_89AB_CDEF, 3, 0, 1'b0, "R3 R2 after rewrite");
      repeat (4) @(posedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule